// File: doc/BRIEF.md
# Systolic Linear Priority Queue

The block keeps up to N keys in a chain of identical cells and serves them smallest-first. Commands arrive at the head cell only: insert a key, extract the minimum, or do nothing. The smallest stored key always sits in the head cell, so an extraction returns its answer in the cycle after the command is taken, whatever the number of keys held. Each cell talks only to its two neighbours. An inserted key that loses a comparison moves one cell further from the head. The gap left by an extraction is refilled from the next cell and so moves toward the tail one step at a time.

Even-numbered and odd-numbered cells update on alternate clock edges. A command therefore reaches the next cell before the head can start the following command, and a hole and a new insertion never meet in the same cell. The head accepts a command on every second cycle and shows this on a ready output. A key counter drives the full flag. The empty flag follows the head cell's valid bit. Single-cycle error pulses report an extraction from an empty queue and an insertion into a full one.

Top module: `sys_pq`

## Requirements
- R1: `ready` is high in the first cycle after reset and then alternates every cycle. A command is taken only at a rising edge where `ready` is high. A command presented while `ready` is low has no effect on the keys, the flags or the outputs. Command codes on `cmd_op`: 2'b01 insert, 2'b10 extract, 2'b00 and 2'b11 idle.
- R2: An accepted extraction from a non-empty queue raises `res_valid` for exactly one cycle, in the cycle after the accepting edge. `res_key` then holds the smallest key stored.
- R3: Keys leave in ascending order whatever the order of insertion. Equal keys are kept as separate entries and each is returned once.
- R4: Commands issued at the full rate (one every two cycles), with inserts and extracts mixed, return the same results as commands issued slowly.
- R5: `empty` is high exactly when no key is held. It is high after reset, clears after the first accepted insert, and rises again after the last key is extracted.
- R6: `full` is high exactly when N keys are held. It holds during a full-rate fill and clears after one extraction.
- R7: An extraction accepted while `empty` is high raises `underflow_err` for one cycle, leaves `res_valid` low, and changes nothing in the queue.
- R8: An insertion accepted while `full` is high raises `overflow_err` for one cycle and discards the key. The stored keys are unchanged.
- R9: Synchronous active-high reset empties the queue: `empty` high, `full` low, and `res_valid`, `underflow_err` and `overflow_err` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_op | input | 2 | Command: 01 insert, 10 extract, others idle |
| cmd_key | input | KEY_W | Key to insert |
| ready | output | 1 | A command is taken at the coming edge |
| res_valid | output | 1 | One-cycle strobe marking an extracted key |
| res_key | output | KEY_W | Extracted minimum key |
| empty | output | 1 | No key is held |
| full | output | 1 | N keys are held |
| underflow_err | output | 1 | Pulse: extraction from an empty queue |
| overflow_err | output | 1 | Pulse: insertion into a full queue |

## Verification
The assertions assume that `cmd_op` and `cmd_key` change only between clock edges and that a command is judged accepted only by the `ready` level at the edge, never by what the environment intended. The bench changes inputs only on falling edges, waits for `ready` before placing a command, and clears it once the accepting edge has passed. The one exception is a deliberate command placed while `ready` is low, which checks that such a command is ignored. Under these conditions every result and error pulse can be traced to one accepted command two edges earlier or fewer.

// File: rtl/spq_pkg.sv
package spq_pkg;

    typedef enum logic [1:0] {
        OP_NONE = 2'b00,
        OP_INS  = 2'b01,
        OP_EXT  = 2'b10
    } op_e;

    // Map a raw command code to an operation; unused code is idle.
    function automatic op_e decode_op(input logic [1:0] raw);
        case (raw)
            2'b01:   return OP_INS;
            2'b10:   return OP_EXT;
            default: return OP_NONE;
        endcase
    endfunction

    // A cell fires when its parity matches the current phase.
    function automatic logic cell_fires(input int unsigned idx, input logic phase);
        return (idx[0] == phase);
    endfunction

endpackage

// File: rtl/spq_cell.sv
module spq_cell
    import spq_pkg::*;
#(
    parameter int KW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          active,
    input  op_e           in_op,
    input  logic [KW-1:0] in_key,
    input  logic          nb_valid,
    input  logic [KW-1:0] nb_key,
    output logic          st_valid,
    output logic [KW-1:0] st_key,
    output op_e           fw_op,
    output logic [KW-1:0] fw_key
);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_valid <= 1'b0;
            st_key   <= '0;
            fw_op    <= OP_NONE;
            fw_key   <= '0;
        end else if (active) begin
            fw_op  <= OP_NONE;
            fw_key <= '0;
            case (in_op)
                OP_INS: begin
                    if (!st_valid) begin
                        st_valid <= 1'b1;
                        st_key   <= in_key;
                    end else if (in_key < st_key) begin
                        st_key <= in_key;
                        fw_op  <= OP_INS;
                        fw_key <= st_key;
                    end else begin
                        fw_op  <= OP_INS;
                        fw_key <= in_key;
                    end
                end
                OP_EXT: begin
                    // Pull the neighbour's settled key up; the hole moves on.
                    st_valid <= nb_valid;
                    st_key   <= nb_key;
                    if (nb_valid) fw_op <= OP_EXT;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/spq_head.sv
module spq_head
    import spq_pkg::*;
#(
    parameter int N  = 16,
    parameter int KW = 16,
    localparam int CW = $clog2(N + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    cmd_op,
    input  logic [KW-1:0] cmd_key,
    input  logic          head_valid,
    input  logic [KW-1:0] head_key,
    output logic          phase,
    output op_e           c0_op,
    output logic [KW-1:0] c0_key,
    output logic          ready,
    output logic          res_valid,
    output logic [KW-1:0] res_key,
    output logic          empty,
    output logic          full,
    output logic          underflow_err,
    output logic          overflow_err
);

    localparam logic [CW-1:0] CAP = CW'(N);

    logic [CW-1:0] count;
    op_e           req;
    logic          take_ins, take_ext, bad_ins, bad_ext;

    assign ready    = (phase == 1'b0);
    assign req      = decode_op(cmd_op);
    assign empty    = !head_valid;
    assign full     = (count == CAP);
    assign take_ins = ready && (req == OP_INS) && !full;
    assign take_ext = ready && (req == OP_EXT) && !empty;
    assign bad_ins  = ready && (req == OP_INS) && full;
    assign bad_ext  = ready && (req == OP_EXT) && empty;

    always_comb begin
        c0_op  = OP_NONE;
        c0_key = cmd_key;
        if (take_ins)      c0_op = OP_INS;
        else if (take_ext) c0_op = OP_EXT;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase         <= 1'b0;
            count         <= '0;
            res_valid     <= 1'b0;
            res_key       <= '0;
            underflow_err <= 1'b0;
            overflow_err  <= 1'b0;
        end else begin
            phase         <= !phase;
            res_valid     <= take_ext;
            underflow_err <= bad_ext;
            overflow_err  <= bad_ins;
            if (take_ext) res_key <= head_key;
            if (take_ins)      count <= count + 1'b1;
            else if (take_ext) count <= count - 1'b1;
        end
    end

endmodule

// File: rtl/sys_pq.sv
module sys_pq
    import spq_pkg::*;
#(
    parameter int N     = 16,
    parameter int KEY_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       cmd_op,
    input  logic [KEY_W-1:0] cmd_key,
    output logic             ready,
    output logic             res_valid,
    output logic [KEY_W-1:0] res_key,
    output logic             empty,
    output logic             full,
    output logic             underflow_err,
    output logic             overflow_err
);

    logic             phase;
    logic             st_vld [N];
    logic [KEY_W-1:0] st_key [N];
    op_e              msg_op [N+1];
    logic [KEY_W-1:0] msg_key[N+1];

    spq_head #(.N(N), .KW(KEY_W)) u_head (
        .clk          (clk),
        .rst          (rst),
        .cmd_op       (cmd_op),
        .cmd_key      (cmd_key),
        .head_valid   (st_vld[0]),
        .head_key     (st_key[0]),
        .phase        (phase),
        .c0_op        (msg_op[0]),
        .c0_key       (msg_key[0]),
        .ready        (ready),
        .res_valid    (res_valid),
        .res_key      (res_key),
        .empty        (empty),
        .full         (full),
        .underflow_err(underflow_err),
        .overflow_err (overflow_err)
    );

    for (genvar i = 0; i < N; i++) begin : g_cell
        logic             nb_v;
        logic [KEY_W-1:0] nb_k;
        if (i == N - 1) begin : g_tail
            assign nb_v = 1'b0;
            assign nb_k = '0;
        end else begin : g_mid
            assign nb_v = st_vld[i+1];
            assign nb_k = st_key[i+1];
        end
        spq_cell #(.KW(KEY_W)) u_cell (
            .clk     (clk),
            .rst     (rst),
            .active  (cell_fires(i, phase)),
            .in_op   (msg_op[i]),
            .in_key  (msg_key[i]),
            .nb_valid(nb_v),
            .nb_key  (nb_k),
            .st_valid(st_vld[i]),
            .st_key  (st_key[i]),
            .fw_op   (msg_op[i+1]),
            .fw_key  (msg_key[i+1])
        );
    end

endmodule

// File: rtl/spq_checker.sv
module spq_checker (
    input logic       clk,
    input logic       rst,
    input logic [1:0] cmd_op,
    input logic       ready,
    input logic       res_valid,
    input logic       empty,
    input logic       full,
    input logic       underflow_err,
    input logic       overflow_err
);

    a_r1_ready_falls: assert property (@(posedge clk) disable iff (rst)
        ready |=> !ready);
    a_r1_ready_rises: assert property (@(posedge clk) disable iff (rst)
        !ready |=> ready);
    a_r2_result_cause: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> $past(ready && cmd_op == 2'b10 && !empty));
    a_r2_single_pulse: assert property (@(posedge clk) disable iff (rst)
        res_valid |=> !res_valid);
    a_r5_r6_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(empty && full));
    a_r6_full_holds: assert property (@(posedge clk) disable iff (rst)
        (full && !(ready && cmd_op == 2'b10)) |=> full);
    a_r7_underflow_cause: assert property (@(posedge clk) disable iff (rst)
        underflow_err |-> ($past(ready && cmd_op == 2'b10 && empty) && !res_valid));
    a_r8_overflow_cause: assert property (@(posedge clk) disable iff (rst)
        overflow_err |-> ($past(ready && cmd_op == 2'b01 && full) && full));

endmodule

bind sys_pq spq_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .cmd_op       (cmd_op),
    .ready        (ready),
    .res_valid    (res_valid),
    .empty        (empty),
    .full         (full),
    .underflow_err(underflow_err),
    .overflow_err (overflow_err)
);

// File: tb/tb_sys_pq.sv
module tb_sys_pq;

    localparam int N  = 16;
    localparam int KW = 16;
    localparam int STEPS = 13;
    localparam int LIMIT = 20000;

    // {expect_underflow, op[1:0], key[15:0], expected_key[15:0]}
    localparam logic [34:0] VEC [STEPS] = '{
        {1'b0, 2'b01, 16'd50, 16'd0},
        {1'b0, 2'b01, 16'd20, 16'd0},
        {1'b0, 2'b01, 16'd70, 16'd0},
        {1'b0, 2'b10, 16'd0,  16'd20},
        {1'b0, 2'b01, 16'd10, 16'd0},
        {1'b0, 2'b10, 16'd0,  16'd10},
        {1'b0, 2'b10, 16'd0,  16'd50},
        {1'b0, 2'b01, 16'd50, 16'd0},
        {1'b0, 2'b01, 16'd50, 16'd0},
        {1'b0, 2'b10, 16'd0,  16'd50},
        {1'b0, 2'b10, 16'd0,  16'd50},
        {1'b0, 2'b10, 16'd0,  16'd70},
        {1'b1, 2'b10, 16'd0,  16'd0}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [1:0]    cmd_op = 2'b00;
    logic [KW-1:0] cmd_key = '0;
    logic          ready, res_valid, empty, full, underflow_err, overflow_err;
    logic [KW-1:0] res_key;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 0;

    always #10 clk = !clk;

    sys_pq #(.N(N), .KEY_W(KW)) dut (
        .clk(clk), .rst(rst), .cmd_op(cmd_op), .cmd_key(cmd_key),
        .ready(ready), .res_valid(res_valid), .res_key(res_key),
        .empty(empty), .full(full),
        .underflow_err(underflow_err), .overflow_err(overflow_err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Place a command when ready, hold it over the accepting edge, then clear.
    task automatic issue(input logic [1:0] op, input logic [KW-1:0] key);
        @(negedge clk);
        while (!ready) @(negedge clk);
        cmd_op  = op;
        cmd_key = key;
        @(negedge clk);
        cmd_op  = 2'b00;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        cmd_op = 2'b00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles == LIMIT && !done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected<%0d cycles", cycles, LIMIT);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R9 / R5: reset state
        chk("R9 empty", 32'(empty), 1);
        chk("R9 full", 32'(full), 0);
        chk("R9 res_valid", 32'(res_valid), 0);
        chk("R9 errs", 32'(underflow_err | overflow_err), 0);
        chk("R1 ready after reset", 32'(ready), 1);

        // R2, R3, R4, R7: table walked at full rate
        for (int s = 0; s < STEPS; s++) begin
            issue(VEC[s][33:32], VEC[s][31:16]);
            chk("R1 ready low after accept", 32'(ready), 0);
            if (VEC[s][34]) begin
                chk("R7 underflow pulse", 32'(underflow_err), 1);
                chk("R7 no result", 32'(res_valid), 0);
            end else if (VEC[s][33:32] == 2'b10) begin
                chk("R2 res_valid", 32'(res_valid), 1);
                chk("R3 R4 res_key", 32'(res_key), 32'(VEC[s][15:0]));
            end else begin
                chk("R5 not empty after insert", 32'(empty), 0);
            end
        end
        @(negedge clk);
        chk("R2 single pulse", 32'(res_valid | underflow_err), 0);
        chk("R5 empty after drain", 32'(empty), 1);

        // R1: command while ready is low is ignored
        @(negedge clk);
        while (ready) @(negedge clk);
        cmd_op = 2'b01; cmd_key = 16'd5;
        @(negedge clk);
        cmd_op = 2'b00;
        chk("R1 ignored insert keeps empty", 32'(empty), 1);
        issue(2'b10, '0);
        chk("R1 ignored insert: underflow", 32'(underflow_err), 1);

        // R6, R8, R3: fill descending, overflow, drain ascending
        for (int k = N; k >= 1; k--) begin
            chk("R6 not full while filling", 32'(full), 0);
            issue(2'b01, KW'(3 * k));
        end
        chk("R6 full", 32'(full), 1);
        issue(2'b01, 16'd0);
        chk("R8 overflow pulse", 32'(overflow_err), 1);
        chk("R8 still full", 32'(full), 1);
        for (int k = 1; k <= N; k++) begin
            issue(2'b10, '0);
            chk("R3 R8 drain order", 32'(res_key), 32'(3 * k));
            if (k == 1) chk("R6 full clears", 32'(full), 0);
        end
        chk("R5 empty after full drain", 32'(empty), 1);

        // R9: reset with keys held
        issue(2'b01, 16'd9);
        issue(2'b01, 16'd4);
        do_reset();
        chk("R9 empty after mid reset", 32'(empty), 1);
        issue(2'b10, '0);
        chk("R9 nothing left", 32'(underflow_err), 1);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule